// File: doc/BRIEF.md
# Codec Soft-Reset Sequencer

This block takes a software run bit from a control register and turns it into the internal reset that an audio codec's digital ADC and DAC paths use. Changes of the bit reach the internal reset only at sample-rate boundaries. Stopping takes longer than restarting. The block never clears control register contents. It only gates data and reports state.

It runs on a system clock and uses a one-cycle sample strobe (`fs_tick`). A change of `run_bit` waits for the next strobe to align, then waits a fixed number of further strobes. Only then does `int_run` follow it. After `int_run` rises, the ADC path goes through a fixed initialization cycle before data reaches its output. The DAC path is enabled as soon as `int_run` rises. While `int_run` is low, ADC samples are forced to zero and the serial data lanes are held low.

Top module: `codec_rst_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `int_run` is 0, `adc_state` is 0, `dac_en` is 0, and `adc_dout` and `sdo_out` are all zero.
- R2: After `run_bit` goes from 1 to 0 and then holds, `int_run` falls at the clock edge of the fifth `fs_tick` that follows the change. The change-to-fall delay is more than 4 and at most 5 sample periods.
- R3: After `run_bit` goes from 0 to 1 and then holds, `int_run` rises at the clock edge of the second `fs_tick` that follows the change. The delay is more than 1 and at most 2 sample periods.
- R4: `int_run` changes only at a clock edge where `fs_tick` is high.
- R5: `adc_state` encodes power-down as 0, init as 1 and normal as 2. One cycle after `int_run` rises it becomes 1. It becomes 2 at the edge of the 516th `fs_tick` after that.
- R6: `adc_dout` equals `adc_din` when `adc_state` is 2. Otherwise it is all zero, including throughout init.
- R7: Each bit of `sdo_out` equals the matching bit of `sdo_din` while `int_run` is 1, and is 0 while `int_run` is 0.
- R8: `dac_en` equals `int_run`, with no init delay.
- R9: A change of `run_bit` restarts any pending count. A pulse of `run_bit` that returns before its delay completes leaves `int_run` unchanged. `int_run` always ends up equal to a steady `run_bit`.
- R10: If `int_run` falls during init, `adc_state` returns to 0 on the next cycle. A later release starts a full 516-tick init again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| fs_tick | input | 1 | One-cycle sample-rate strobe |
| run_bit | input | 1 | Register run bit (0 requests reset) |
| adc_din | input | DATA_W | ADC sample from the decimator |
| sdo_din | input | SDO_N | Serial data lanes before gating |
| int_run | output | 1 | Delayed internal run (active-high) |
| adc_state | output | 2 | ADC path state: 0 power-down, 1 init, 2 normal |
| adc_dout | output | DATA_W | Gated ADC sample |
| sdo_out | output | SDO_N | Gated serial data lanes |
| dac_en | output | 1 | DAC path enable |

## Verification
Two events can land on the same clock edge. The first case is a `run_bit` change on the very edge that carries an `fs_tick`: the tick must not count toward the new delay. The second case is a fall of `int_run` on an edge where the init count is still running: power-down must win over the init progress. The random phase drives `fs_tick` at a fixed period and toggles `run_bit` after random hold times, many of them shorter than the delays. This makes both coincidences occur many times. Every cycle, a bench model built from R2–R10 judges `int_run`, `adc_state` and the gated data. Directed runs measure the exact delay and init length.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;
   typedef enum logic [1:0] {
      ADC_PD   = 2'd0,
      ADC_INIT = 2'd1,
      ADC_RUN  = 2'd2
   } adc_st_e;
endpackage

// File: rtl/codec_rst_tickdelay.sv
// Aligns run-bit changes to the sample strobe and counts extra strobes.
module codec_rst_tickdelay #(
   parameter int ASSERT_TICKS  = 4,
   parameter int RELEASE_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_tick,
   input  logic run_bit,
   output logic int_run
);
   localparam int MAXT = (ASSERT_TICKS > RELEASE_TICKS) ? ASSERT_TICKS : RELEASE_TICKS;
   localparam int CW   = $clog2(MAXT + 2);

   if (ASSERT_TICKS < 1 || RELEASE_TICKS < 1) begin : g_bad_ticks
      $error("tick counts must be at least 1");
   end

   logic          bit_q;
   logic          run_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;
   logic          moved;
   logic          pending;

   assign limit   = run_bit ? CW'(RELEASE_TICKS) : CW'(ASSERT_TICKS);
   assign moved   = run_bit != bit_q;
   assign pending = run_bit != run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= 1'b0;
         run_q <= 1'b0;
         cnt   <= '0;
      end else begin
         bit_q <= run_bit;
         if (moved || !pending) begin
            cnt <= '0;
         end else if (fs_tick) begin
            if (cnt == limit) begin
               run_q <= run_bit;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign int_run = run_q;

   p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != $past(run_q)) |-> $past(fs_tick));
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXT));
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_bit == run_q) |=> (cnt == '0));
endmodule

// File: rtl/codec_rst_initseq.sv
// ADC path state: power-down, init cycle of INIT_TICKS strobes, normal.
module codec_rst_initseq
   import codec_rst_pkg::*;
#(
   parameter int INIT_TICKS = 516
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fs_tick,
   input  logic    int_run,
   output adc_st_e state
);
   localparam int IW = $clog2(INIT_TICKS + 1);

   if (INIT_TICKS < 2) begin : g_bad_init
      $error("INIT_TICKS must be at least 2");
   end

   adc_st_e       st_q;
   logic [IW-1:0] icnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ADC_PD;
         icnt <= '0;
      end else if (!int_run) begin
         st_q <= ADC_PD;
         icnt <= '0;
      end else begin
         case (st_q)
            ADC_PD: begin
               st_q <= ADC_INIT;
               icnt <= '0;
            end
            ADC_INIT: if (fs_tick) begin
               if (icnt == IW'(INIT_TICKS - 1)) st_q <= ADC_RUN;
               else                             icnt <= icnt + 1'b1;
            end
            default: st_q <= ADC_RUN;
         endcase
      end
   end

   assign state = st_q;

   p_pd_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !int_run |=> (st_q == ADC_PD));
   p_enter_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_run) |=> (st_q == ADC_INIT));
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      icnt < IW'(INIT_TICKS));
   p_run_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ADC_RUN && $past(st_q) == ADC_INIT) |-> $past(fs_tick));
endmodule

// File: rtl/codec_rst_gate.sv
// Data gating for ADC samples and serial lanes; optional output register.
module codec_rst_gate #(
   parameter int DATA_W   = 24,
   parameter int SDO_N    = 2,
   parameter bit REG_GATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adc_open,
   input  logic              lane_open,
   input  logic [DATA_W-1:0] adc_din,
   input  logic [SDO_N-1:0]  sdo_din,
   output logic [DATA_W-1:0] adc_dout,
   output logic [SDO_N-1:0]  sdo_out
);
   if (DATA_W < 1 || SDO_N < 1) begin : g_bad_w
      $error("DATA_W and SDO_N must be positive");
   end

   logic [DATA_W-1:0] adc_g;
   logic [SDO_N-1:0]  sdo_g;

   assign adc_g = adc_open ? adc_din : '0;

   for (genvar i = 0; i < SDO_N; i++) begin : g_lane
      assign sdo_g[i] = sdo_din[i] & lane_open;
   end

   if (REG_GATE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            adc_dout <= '0;
            sdo_out  <= '0;
         end else begin
            adc_dout <= adc_g;
            sdo_out  <= sdo_g;
         end
      end
   end else begin : g_comb
      assign adc_dout = adc_g;
      assign sdo_out  = sdo_g;
   end
endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq
   import codec_rst_pkg::*;
#(
   parameter int DATA_W        = 24,
   parameter int SDO_N         = 2,
   parameter int ASSERT_TICKS  = 4,
   parameter int RELEASE_TICKS = 1,
   parameter int INIT_TICKS    = 516,
   parameter bit REG_GATE      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_tick,
   input  logic              run_bit,
   input  logic [DATA_W-1:0] adc_din,
   input  logic [SDO_N-1:0]  sdo_din,
   output logic              int_run,
   output logic [1:0]        adc_state,
   output logic [DATA_W-1:0] adc_dout,
   output logic [SDO_N-1:0]  sdo_out,
   output logic              dac_en
);
   adc_st_e st;

   codec_rst_tickdelay #(
      .ASSERT_TICKS (ASSERT_TICKS),
      .RELEASE_TICKS(RELEASE_TICKS)
   ) u_delay (
      .clk    (clk),
      .rst_n  (rst_n),
      .fs_tick(fs_tick),
      .run_bit(run_bit),
      .int_run(int_run)
   );

   codec_rst_initseq #(
      .INIT_TICKS(INIT_TICKS)
   ) u_init (
      .clk    (clk),
      .rst_n  (rst_n),
      .fs_tick(fs_tick),
      .int_run(int_run),
      .state  (st)
   );

   codec_rst_gate #(
      .DATA_W  (DATA_W),
      .SDO_N   (SDO_N),
      .REG_GATE(REG_GATE)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .adc_open (st == ADC_RUN),
      .lane_open(int_run),
      .adc_din  (adc_din),
      .sdo_din  (sdo_din),
      .adc_dout (adc_dout),
      .sdo_out  (sdo_out)
   );

   assign adc_state = st;
   assign dac_en    = int_run;

   p_init_blocks_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_GATE && st == ADC_INIT) |-> (adc_dout == '0));
   p_pd_lanes_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_GATE && !int_run) |-> (sdo_out == '0));
endmodule

// File: tb/codec_rst_seq_tb.sv
`timescale 1ns/100ps
module codec_rst_seq_tb;
   localparam int DW   = 24;
   localparam int SN   = 2;
   localparam int ASRT = 4;
   localparam int REL  = 1;
   localparam int INIT = 516;
   localparam int P    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fs_tick = 1'b0;
   logic          run_bit = 1'b0;
   logic [DW-1:0] adc_din = '0;
   logic [SN-1:0] sdo_din = '0;
   logic          int_run;
   logic [1:0]    adc_state;
   logic [DW-1:0] adc_dout;
   logic [SN-1:0] sdo_out;
   logic          dac_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int div    = 0;

   always #2.5 clk = ~clk;

   codec_rst_seq u_dut (
      .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .run_bit(run_bit),
      .adc_din(adc_din), .sdo_din(sdo_din), .int_run(int_run),
      .adc_state(adc_state), .adc_dout(adc_dout), .sdo_out(sdo_out),
      .dac_en(dac_en)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // strobe and data drivers (negedge)
   always @(negedge clk) begin
      fs_tick <= (div == P - 1);
      div     <= (div == P - 1) ? 0 : div + 1;
      adc_din <= DW'($urandom);
      sdo_din <= SN'($urandom);
   end

   // reference model built from the requirements
   bit m_last, m_run;
   int m_seen, m_st, m_icnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_last <= 0; m_run <= 0; m_seen <= 0; m_st <= 0; m_icnt <= 0;
      end else begin
         m_last <= run_bit;
         if (run_bit != m_last || run_bit == m_run) m_seen <= 0;
         else if (fs_tick) begin
            if (m_seen == (run_bit ? REL : ASRT)) begin
               m_run <= run_bit; m_seen <= 0;
            end else m_seen <= m_seen + 1;
         end
         if (!m_run) begin m_st <= 0; m_icnt <= 0; end
         else if (m_st == 0) begin m_st <= 1; m_icnt <= 0; end
         else if (m_st == 1 && fs_tick) begin
            if (m_icnt == INIT - 1) m_st <= 2; else m_icnt <= m_icnt + 1;
         end
      end
   end

   always begin
      @(negedge clk); #1;
      if (rst_n && !done) begin
         chk(int_run === m_run, "R4/R9 int_run", int_run, m_run);
         chk(adc_state === 2'(m_st), "R5/R10 adc_state", adc_state, m_st);
         chk(adc_dout === ((m_st == 2) ? adc_din : '0), "R6 adc_dout", adc_dout,
             (m_st == 2) ? adc_din : 0);
         chk(sdo_out === (m_run ? sdo_din : '0), "R7 sdo_out", sdo_out, m_run ? sdo_din : 0);
         chk(dac_en === m_run, "R8 dac_en", dac_en, m_run);
      end
   end

   task automatic measure(input bit v, input int n, input string tag);
      int k = 0;
      @(negedge clk); run_bit = v;
      do begin @(negedge clk); #1; k++; end while (int_run !== v && k < 100);
      chk((k - 1) > n * P && (k - 1) <= (n + 1) * P, tag, k - 1, (n + 1) * P);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int k;
      void'($urandom(32'h5eed_0a11));
      idle(4); #1;
      // R1 reset state
      chk(int_run === 0 && dac_en === 0, "R1 run in reset", int_run, 0);
      chk(adc_state === 0 && adc_dout === '0 && sdo_out === '0, "R1 outputs in reset", adc_state, 0);
      @(negedge clk); rst_n = 1; @(negedge clk); #1;
      chk(int_run === 0 && adc_state === 0 && sdo_out === '0, "R1 after release", adc_state, 0);
      // R9 short pulse ignored
      @(negedge clk); run_bit = 1; idle(5); run_bit = 0; idle(60); #1;
      chk(int_run === 0, "R9 short pulse", int_run, 0);
      // R3 release delay
      measure(1, REL, "R3 release delay");
      // R5 init length: INIT ticks at period P after entry
      k = 0;
      @(negedge clk); #1;
      while (adc_state === 2'd1 && k < 5000) begin @(negedge clk); #1; k++; end
      chk(k == INIT * P - 1, "R5 init length", k, INIT * P - 1);
      chk(adc_state === 2'd2, "R5 normal reached", adc_state, 2);
      // R2 assert delay
      measure(0, ASRT, "R2 assert delay");
      idle(3); #1;
      chk(adc_state === 0 && adc_dout === '0, "R6 data zero in pd", adc_state, 0);
      // R10 fall during init
      measure(1, REL, "R3 second release");
      idle(1500); #1;
      chk(adc_state === 2'd1 && adc_dout === '0, "R6 zero during init", adc_dout, 0);
      @(negedge clk); run_bit = 0;
      idle(45); #1;
      chk(adc_state === 0 && int_run === 0, "R10 init aborted", adc_state, 0);
      measure(1, REL, "R10 re-release");
      idle(2); #1;
      chk(adc_state === 2'd1, "R10 init restarted", adc_state, 1);
      // random phase
      for (int i = 0; i < 60; i++) begin
         @(negedge clk); run_bit = ~run_bit;
         if (($urandom % 12) == 0) idle(4200);
         else idle($urandom_range(1, 60));
      end
      idle(4300); #1;
      chk(int_run === run_bit, "R9 settles to bit", int_run, run_bit);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule